// File: doc/BRIEF.md
# Unaddressed Invalidation Transaction Tracker

This block sits beside a core's memory sequencer. It keeps the translation-invalidate operations that carry no address apart from the ordinary line-addressed traffic. A plain invalidate or an invalidate-sync issued by the core receives a fresh 64-bit transaction identifier. The request is parked in a small associative table under that identifier and is acknowledged in the same cycle. Such requests never pass the cache-line lock check that addressed traffic undergoes.

When the fabric reports that one of these operations has finished, the tracker finds the parked entry, checks that its kind agrees and frees the slot. One cycle later it hands the core's original tag back. An external sync arriving from the fabric is not looked up at all. It is passed to the core as a stale-translation notice carrying the received identifier. An outgoing sync-complete takes its identifier from the caller and uses no slot.

Two small state machines shape the outputs. The response machine has states RSP_IDLE, RSP_DONE and RSP_STALE. Its transitions are *retire* (to RSP_DONE), *notify* (to RSP_STALE) and *quiet* (back to RSP_IDLE), and every transition is re-evaluated on each clock. The health machine has states HL_CLEAN and HL_FAULT. Its only transition is *fault* (HL_CLEAN to HL_FAULT), and HL_FAULT is left only by reset.

Top module: `unaddr_txn_tracker`

## Requirements
- R1: For kinds 0 and 1, `iss_id` is combinational. Bits 63:32 hold the `VERSION` parameter. Bits 31:0 hold the counter's next value shifted left by `OFS_BITS`. The counter is zero after reset, so the first identifier uses count 1.
- R2: The counter advances only when a kind 0 or 1 issue is accepted. When the incremented count shifted by `OFS_BITS` no longer fits in 32 bits, the count becomes 0 instead.
- R3: An issue of kind 3 (sync-complete) is always ready. Its `iss_id` equals `iss_ext_id`. It neither stores an entry nor moves the counter.
- R4: A kind 0 or 1 issue is ready in the same cycle and occupies a slot from the following edge. With all `DEPTH` slots valid it is not ready.
- R5: A kind 0 or 1 issue whose next identifier is already held by a valid slot is refused, and the counter holds.
- R6: A completion of kind 2 (external sync) does no table search. In the next cycle it raises `stale_valid` for one cycle, with `stale_id` equal to the received identifier.
- R7: A completion of kind 0 or 1 whose identifier is held by a slot of the same kind frees that slot. In the next cycle it raises `done_valid` for one cycle, with `done_tag` equal to the stored tag.
- R8: A completion of kind 3, or of kind 0 or 1 with no matching identifier or with a different stored kind, sets `err_flag` from the next edge. The table is left as it was. The flag stays high until reset.
- R9: `seq_empty` is high exactly when `addr_tbl_empty` is high and no slot is valid.
- R10: Kind encodings are 0 invalidate, 1 invalidate-sync, 2 external sync, 3 sync-complete. An issue of kind 2 is never ready.
- R11: During and right after reset, `done_valid`, `stale_valid` and `err_flag` are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Core presents an unaddressed request |
| iss_kind | input | 2 | Request kind (R10 encoding) |
| iss_tag | input | TAG_W | Core tag returned on completion |
| iss_ext_id | input | 64 | Identifier supplied with a sync-complete |
| iss_ready | output | 1 | Request accepted this cycle |
| iss_id | output | 64 | Identifier given to the request |
| cmp_valid | input | 1 | Fabric delivers a completion or external sync |
| cmp_kind | input | 2 | Kind of the incoming message |
| cmp_id | input | 64 | Identifier of the incoming message |
| done_valid | output | 1 | One-cycle completion pulse to the core |
| done_tag | output | TAG_W | Tag of the completed request |
| stale_valid | output | 1 | One-cycle stale-translation notice |
| stale_id | output | 64 | Identifier carried by the notice |
| err_flag | output | 1 | Sticky protocol error |
| addr_tbl_empty | input | 1 | Addressed request table holds nothing |
| seq_empty | output | 1 | Both tables empty |

## Verification
The bench sets the counter's shift near the top of the word so that the count runs through only eight values. This lets a full sweep show the wrap apart from plain increment. It also creates real identifier collisions, which separate the duplicate refusal from the full-table stall. Completions come in four forms: a matching one, one with an unknown identifier, one of the wrong kind and an external sync. These tell retirement, the two error paths and the lookup-free notification apart. An issue and a completion in the same cycle show that the duplicate check sees the table as it stood before the edge. Sync-complete issues placed between plain invalidates show that the counter and the table are left untouched.

// File: rtl/uit_pkg.sv
package uit_pkg;
    typedef enum logic [1:0] {
        K_INVAL      = 2'd0,
        K_INVAL_SYNC = 2'd1,
        K_EXT_SYNC   = 2'd2,
        K_EXT_DONE   = 2'd3
    } uit_kind_e;

    typedef enum logic {
        HL_CLEAN = 1'b0,
        HL_FAULT = 1'b1
    } uit_health_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_STALE = 2'd2
    } uit_rsp_e;
endpackage

// File: rtl/uit_id_gen.sv
module uit_id_gen #(
    parameter logic [31:0] VERSION  = 32'h0000_0001,
    parameter int          OFS_BITS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    output logic [63:0] next_id
);
    localparam int CNT_W = 32 - OFS_BITS;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        // carry out means the shifted value left the low word: restart at zero
        cnt_nxt = cnt_inc[CNT_W] ? '0 : cnt_inc[CNT_W-1:0];
        next_id = {VERSION, cnt_nxt, {OFS_BITS{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (advance) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/uit_table.sv
module uit_table #(
    parameter  int DEPTH = 8,
    parameter  int TAG_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [63:0]      ins_id,
    input  logic [1:0]       ins_kind,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [63:0]      lk_id,
    input  logic             ret_en,
    output logic             lk_hit,
    output logic [1:0]       lk_kind,
    output logic [TAG_W-1:0] lk_tag,
    output logic             ins_dup,
    output logic             full,
    output logic [DEPTH-1:0] vld_o
);
    logic [DEPTH-1:0] vld_q;
    logic [63:0]      id_q   [DEPTH];
    logic [1:0]       kind_q [DEPTH];
    logic [TAG_W-1:0] tag_q  [DEPTH];

    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] dup_vec;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (id_q[g] == lk_id);
        assign dup_vec[g] = vld_q[g] && (id_q[g] == ins_id);
    end

    // lowest matching slot and lowest free slot
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx  = IDX_W'(i);
            if (!vld_q[i])  free_idx = IDX_W'(i);
        end
    end

    assign lk_hit  = |hit_vec;
    assign lk_kind = kind_q[hit_idx];
    assign lk_tag  = tag_q[hit_idx];
    assign ins_dup = |dup_vec;
    assign full    = &vld_q;
    assign vld_o   = vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ret_en && lk_hit && (hit_idx == IDX_W'(i))) vld_q[i] <= 1'b0;
                if (ins_en && !full && (free_idx == IDX_W'(i))) vld_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (ins_en && !full && (free_idx == IDX_W'(i))) begin
                id_q[i]   <= ins_id;
                kind_q[i] <= ins_kind;
                tag_q[i]  <= ins_tag;
            end
        end
    end
endmodule

// File: rtl/uit_health.sv
module uit_health
    import uit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_evt,
    output logic err
);
    uit_health_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HL_CLEAN: if (fault_evt) st_d = HL_FAULT;
            HL_FAULT: st_d = HL_FAULT;
            default:  st_d = HL_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HL_CLEAN;
        else        st_q <= st_d;
    end

    always_comb begin
        err = 1'b0;
        unique case (st_q)
            HL_CLEAN: err = 1'b0;
            HL_FAULT: err = 1'b1;
            default:  err = 1'b0;
        endcase
    end
endmodule

// File: rtl/uit_resp.sv
module uit_resp
    import uit_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic [TAG_W-1:0] retire_tag,
    input  logic             notify,
    input  logic [63:0]      notify_id,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag,
    output logic             stale_valid,
    output logic [63:0]      stale_id
);
    uit_rsp_e         st_q, st_d;
    logic [TAG_W-1:0] tag_q;
    logic [63:0]      sid_q;

    always_comb begin
        st_d = RSP_IDLE;
        unique case (1'b1)
            retire:  st_d = RSP_DONE;
            notify:  st_d = RSP_STALE;
            default: st_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RSP_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (retire) tag_q <= retire_tag;
        if (notify) sid_q <= notify_id;
    end

    always_comb begin
        done_valid  = 1'b0;
        stale_valid = 1'b0;
        unique case (st_q)
            RSP_IDLE:  ;
            RSP_DONE:  done_valid  = 1'b1;
            RSP_STALE: stale_valid = 1'b1;
            default:   ;
        endcase
        done_tag = tag_q;
        stale_id = sid_q;
    end
endmodule

// File: rtl/unaddr_txn_tracker.sv
module unaddr_txn_tracker
    import uit_pkg::*;
#(
    parameter logic [31:0] VERSION  = 32'h0000_0001,
    parameter int          OFS_BITS = 6,
    parameter int          DEPTH    = 8,
    parameter int          TAG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [1:0]       iss_kind,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic [63:0]      iss_ext_id,
    output logic             iss_ready,
    output logic [63:0]      iss_id,
    input  logic             cmp_valid,
    input  logic [1:0]       cmp_kind,
    input  logic [63:0]      cmp_id,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag,
    output logic             stale_valid,
    output logic [63:0]      stale_id,
    output logic             err_flag,
    input  logic             addr_tbl_empty,
    output logic             seq_empty
);
    logic [63:0]      gen_id;
    logic             tbl_full, tbl_dup, tbl_hit;
    logic [1:0]       tbl_kind;
    logic [TAG_W-1:0] tbl_tag;
    logic [DEPTH-1:0] tbl_vld;
    logic             do_insert, do_retire, do_notify, do_fault;

    uit_kind_e ik, ck;
    assign ik = uit_kind_e'(iss_kind);
    assign ck = uit_kind_e'(cmp_kind);

    // issue decode
    always_comb begin
        iss_ready = 1'b0;
        iss_id    = gen_id;
        unique case (ik)
            K_INVAL, K_INVAL_SYNC: iss_ready = !tbl_full && !tbl_dup;
            K_EXT_SYNC:            iss_ready = 1'b0;
            K_EXT_DONE: begin
                iss_ready = 1'b1;
                iss_id    = iss_ext_id;
            end
            default:               iss_ready = 1'b0;
        endcase
        do_insert = iss_valid && iss_ready &&
                    ((ik == K_INVAL) || (ik == K_INVAL_SYNC));
    end

    // completion decode
    always_comb begin
        do_retire = 1'b0;
        do_notify = 1'b0;
        do_fault  = 1'b0;
        if (cmp_valid) begin
            unique case (ck)
                K_INVAL, K_INVAL_SYNC: begin
                    if (tbl_hit && (tbl_kind == cmp_kind)) do_retire = 1'b1;
                    else                                   do_fault  = 1'b1;
                end
                K_EXT_SYNC: do_notify = 1'b1;
                K_EXT_DONE: do_fault  = 1'b1;
                default:    do_fault  = 1'b1;
            endcase
        end
    end

    uit_id_gen #(.VERSION(VERSION), .OFS_BITS(OFS_BITS)) u_idgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (do_insert),
        .next_id (gen_id)
    );

    uit_table #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (do_insert),
        .ins_id   (gen_id),
        .ins_kind (iss_kind),
        .ins_tag  (iss_tag),
        .lk_id    (cmp_id),
        .ret_en   (do_retire),
        .lk_hit   (tbl_hit),
        .lk_kind  (tbl_kind),
        .lk_tag   (tbl_tag),
        .ins_dup  (tbl_dup),
        .full     (tbl_full),
        .vld_o    (tbl_vld)
    );

    uit_resp #(.TAG_W(TAG_W)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire      (do_retire),
        .retire_tag  (tbl_tag),
        .notify      (do_notify),
        .notify_id   (cmp_id),
        .done_valid  (done_valid),
        .done_tag    (done_tag),
        .stale_valid (stale_valid),
        .stale_id    (stale_id)
    );

    uit_health u_health (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_evt (do_fault),
        .err       (err_flag)
    );

    assign seq_empty = addr_tbl_empty && !(|tbl_vld);
endmodule

// File: rtl/uit_tracker_chk.sv
module uit_tracker_chk #(
    parameter logic [31:0] VERSION = 32'h0000_0001,
    parameter int          DEPTH   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [1:0]       iss_kind,
    input logic             iss_ready,
    input logic [63:0]      iss_id,
    input logic             cmp_valid,
    input logic [1:0]       cmp_kind,
    input logic [63:0]      cmp_id,
    input logic             done_valid,
    input logic             stale_valid,
    input logic [63:0]      stale_id,
    input logic             err_flag,
    input logic             addr_tbl_empty,
    input logic             seq_empty,
    input logic [DEPTH-1:0] tbl_vld
);
    p_id_version_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_kind[1]) |-> (iss_id[63:32] == VERSION));

    p_done_nostore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind == 2'd3 && !(cmp_valid && cmp_kind[1] == 1'b0))
        |=> ($countones(tbl_vld) == $countones($past(tbl_vld))));

    p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&tbl_vld && iss_valid && !iss_kind[1]) |-> !iss_ready);

    p_stale_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_kind == 2'd2) |=> (stale_valid && stale_id == $past(cmp_id)));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && stale_valid));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_empty_needs_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_empty |-> (addr_tbl_empty && tbl_vld == '0));

    p_ext_never_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_kind == 2'd2) |-> !iss_ready);

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!done_valid && !stale_valid && !err_flag && tbl_vld == '0));
endmodule

bind unaddr_txn_tracker uit_tracker_chk #(.VERSION(VERSION), .DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid      (iss_valid),
    .iss_kind       (iss_kind),
    .iss_ready      (iss_ready),
    .iss_id         (iss_id),
    .cmp_valid      (cmp_valid),
    .cmp_kind       (cmp_kind),
    .cmp_id         (cmp_id),
    .done_valid     (done_valid),
    .stale_valid    (stale_valid),
    .stale_id       (stale_id),
    .err_flag       (err_flag),
    .addr_tbl_empty (addr_tbl_empty),
    .seq_empty      (seq_empty),
    .tbl_vld        (tbl_vld)
);

// File: tb/unaddr_txn_tracker_tb.sv
module unaddr_txn_tracker_tb;
    localparam logic [31:0] VER   = 32'hA5C3_0017;
    localparam int          OFS   = 29;
    localparam int          DEPTH = 8;
    localparam int          TAG_W = 4;
    localparam int          CNT_LIM = 1 << (32 - OFS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [1:0]       iss_kind = '0;
    logic [TAG_W-1:0] iss_tag = '0;
    logic [63:0]      iss_ext_id = '0;
    logic             iss_ready;
    logic [63:0]      iss_id;
    logic             cmp_valid = 1'b0;
    logic [1:0]       cmp_kind = '0;
    logic [63:0]      cmp_id = '0;
    logic             done_valid;
    logic [TAG_W-1:0] done_tag;
    logic             stale_valid;
    logic [63:0]      stale_id;
    logic             err_flag;
    logic             addr_tbl_empty = 1'b1;
    logic             seq_empty;

    always #4 clk = ~clk;

    unaddr_txn_tracker #(.VERSION(VER), .OFS_BITS(OFS), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_tag(iss_tag), .iss_ext_id(iss_ext_id),
        .iss_ready(iss_ready), .iss_id(iss_id),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_id(cmp_id),
        .done_valid(done_valid), .done_tag(done_tag),
        .stale_valid(stale_valid), .stale_id(stale_id),
        .err_flag(err_flag), .addr_tbl_empty(addr_tbl_empty), .seq_empty(seq_empty)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    logic [63:0] q_id[$];
    int          q_kind[$];
    int          q_tag[$];
    int          m_cnt;
    bit          m_err, m_done, m_stale;
    int          m_done_tag;
    logic [63:0] m_stale_id;

    function automatic logic [63:0] mk_id(input int n);
        logic [31:0] lo;
        lo = 32'(n) << OFS;
        return {VER, lo};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        q_id.delete(); q_kind.delete(); q_tag.delete();
        m_cnt = 0; m_err = 0; m_done = 0; m_stale = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; iss_valid = 0; cmp_valid = 0; addr_tbl_empty = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk("R11", "done_valid", 64'(done_valid), 64'd0);
        chk("R11", "stale_valid", 64'(stale_valid), 64'd0);
        chk("R11", "err_flag", 64'(err_flag), 64'd0);
        chk("R11", "seq_empty", 64'(seq_empty), 64'd1);
    endtask

    task automatic step(input bit iv, input int ik, input int itag, input logic [63:0] iext,
                        input bit cv, input int ck, input logic [63:0] cid,
                        input bit ae, input string rq);
        int          nxt, hit, idx;
        bit          present, exp_rdy, n_done, n_stale;
        logic [63:0] mid, exp_id;
        @(negedge clk);
        iss_valid = iv; iss_kind = 2'(ik); iss_tag = TAG_W'(itag); iss_ext_id = iext;
        cmp_valid = cv; cmp_kind = 2'(ck); cmp_id = cid; addr_tbl_empty = ae;
        #1;
        nxt = m_cnt + 1;
        if (nxt >= CNT_LIM) nxt = 0;
        mid = mk_id(nxt);
        present = 0;
        foreach (q_id[i]) if (q_id[i] == mid) present = 1;
        case (ik)
            3:       begin exp_rdy = 1; exp_id = iext; end
            2:       begin exp_rdy = 0; exp_id = mid; end
            default: begin exp_rdy = (q_id.size() < DEPTH) && !present; exp_id = mid; end
        endcase
        if (iv) begin
            chk(rq, "iss_ready", 64'(iss_ready), 64'(exp_rdy));
            if (ik != 2) chk(rq, "iss_id", iss_id, exp_id);
        end
        chk("R9", "seq_empty", 64'(seq_empty), 64'(ae && q_id.size() == 0));
        chk("R8", "err_flag", 64'(err_flag), 64'(m_err));
        chk("R7", "done_valid", 64'(done_valid), 64'(m_done));
        if (m_done) chk("R7", "done_tag", 64'(done_tag), 64'(m_done_tag));
        chk("R6", "stale_valid", 64'(stale_valid), 64'(m_stale));
        if (m_stale) chk("R6", "stale_id", stale_id, m_stale_id);
        // model update for the coming edge
        n_done = 0; n_stale = 0; idx = -1;
        if (cv) begin
            hit = -1;
            foreach (q_id[i]) if (hit < 0 && q_id[i] == cid) hit = i;
            case (ck)
                2: begin n_stale = 1; m_stale_id = cid; end
                3: m_err = 1;
                default: begin
                    if (hit >= 0 && q_kind[hit] == ck) begin
                        n_done = 1; m_done_tag = q_tag[hit]; idx = hit;
                    end else m_err = 1;
                end
            endcase
        end
        if (idx >= 0) begin q_id.delete(idx); q_kind.delete(idx); q_tag.delete(idx); end
        if (iv && exp_rdy && ik < 2) begin
            q_id.push_back(mid); q_kind.push_back(ik); q_tag.push_back(itag); m_cnt = nxt;
        end
        m_done = n_done; m_stale = n_stale;
        @(posedge clk);
    endtask

    task automatic iss(input int k, input int tag, input string rq);
        step(1, k, tag, 64'd0, 0, 0, 64'd0, 1, rq);
    endtask

    task automatic cmp(input int k, input logic [63:0] id);
        step(0, 0, 0, 64'd0, 1, k, id, 1, "R7");
    endtask

    task automatic idle(input bit ae);
        step(0, 0, 0, 64'd0, 0, 0, 64'd0, ae, "R9");
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: identifiers with counts 1 and 2
        iss(0, 1, "R1");
        iss(1, 2, "R1");
        // R3: sync-complete uses the supplied id, counter untouched
        step(1, 3, 0, 64'h0123_4567_89AB_CDEF, 0, 0, 64'd0, 1, "R3");
        iss(0, 3, "R3");
        // R10: external sync kind is never accepted on issue
        iss(2, 0, "R10");
        // R6: external sync notification
        cmp(2, 64'hFEED_0000_0000_1234);
        // R7: matching completion
        cmp(0, mk_id(1));
        idle(1);
        // R8: unknown id, then table still intact
        cmp(1, 64'h1);
        cmp(1, mk_id(2));
        cmp(0, mk_id(3));
        idle(1);
        do_reset();
        // R4 / R2: fill the table across the wrap
        for (int i = 0; i < 7; i++) iss(0, i, "R1");
        iss(0, 7, "R2");
        iss(0, 8, "R4");
        step(1, 3, 0, 64'h5555_AAAA_0000_0001, 0, 0, 64'd0, 1, "R3");
        // R5: next id collides with a live slot
        cmp(0, mk_id(5));
        iss(0, 9, "R5");
        step(1, 0, 10, 64'd0, 1, 0, mk_id(1), 1, "R5");
        iss(0, 11, "R5");
        // R8: kind mismatch leaves entry, then correct kind retires it
        cmp(1, mk_id(2));
        cmp(0, mk_id(2));
        // R9: drain with the addressed table busy, then idle
        step(0, 0, 0, 64'd0, 1, 0, mk_id(3), 0, "R9");
        cmp(0, mk_id(4));
        cmp(0, mk_id(6));
        cmp(0, mk_id(7));
        cmp(0, mk_id(0));
        cmp(0, mk_id(1));
        idle(0);
        idle(1);
        idle(1);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule